// File: doc/BRIEF.md
# Dual-Pair Edge/Center-Aligned PWM Generator

This block is a PWM timebase that drives two complementary output pairs, A and B. A 16-bit period value sets how many clock ticks make up one switching period. In edge-aligned counting the period is that many ticks. In center-aligned counting the value sets half the period, so a full period is twice that many ticks. Each pair has a signed 16-bit duty value, which gives the on-time of its high-side output in clock ticks. The low-side output is the inverse of the high side.

Software writes the period and the two duty values through a small write port into staging registers. At the first tick of every period the timebase copies the staged period, the staged duties and the counting mode into its active set, and it raises a one-tick sync pulse. A write therefore never changes a period that is already running. A staged period of 0 or 1 is illegal. With an illegal period, or with the enable low, all four outputs are held low.

Top module: `pwm_dual_pair`

## Requirements
- R1: In edge-aligned mode (`center_mode` = 0 at the period start) one period lasts exactly P ticks, where P is the active period value, and `sync` is high on the first tick of each period only.
- R2: In center-aligned mode (`center_mode` = 1 at the period start) one period lasts exactly 2·P ticks. The internal count runs up from 0 to P-1 and then down from P to 1. `sync` is high on the first tick only.
- R3: In edge-aligned mode, with a clamped duty value D, the high side of a pair is on for ticks 0 to D-1 of the period and off for the rest.
- R4: In center-aligned mode, with a clamped duty value D, the high side is on while the count is below D on the way up and at most D on the way down. That is ticks 0 to D-1 and ticks 2P-D to 2P-1, so 2·D ticks per period.
- R5: While a period is running, each low-side output is the inverse of its high-side output. When no period is running, all four outputs are low.
- R6: A negative duty value (two's complement) gives 0% on-time. A duty value at or above P gives 100% on-time.
- R7: If the staged period is 0 or 1 at a period start, no period runs: all outputs stay low and `sync` stays low. The block retries the load on every tick until a legal period is staged.
- R8: Writes land in staging registers on the clock edge on which `wr_en` is high. The active period, duties and mode change only at a period start. A start taken on the same edge as a write uses the staged values from before that write.
- R9: While `en` is low the counter is cleared and no period runs. On the first edge with `en` high, a period starts, and `sync` is high in the following cycle.
- R10: `wr_addr` selects the staging register: 0 is the period, 1 is duty A, 2 is duty B. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of the PWM timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the block idle |
| center_mode | input | 1 | 1 selects center-aligned counting, 0 edge-aligned; sampled at period start |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_addr | input | 2 | Staging register select (0 period, 1 duty A, 2 duty B, 3 unused) |
| wr_data | input | 16 | Write data; duties are two's complement |
| a_hi | output | 1 | Pair A high-side output |
| a_lo | output | 1 | Pair A low-side output |
| b_hi | output | 1 | Pair B high-side output |
| b_lo | output | 1 | Pair B low-side output |
| sync | output | 1 | One-tick pulse on the first tick of each period |

## Verification
The hardest case to produce from the ports is a write that lands on the exact edge where one period ends and the next begins. On that edge the new period must load the old staged value, and the written value must wait one more full period. The bench's reference model tracks the tick position inside the current period. It uses that position to place a write on the final tick, for both counting modes, and for both the period and the duty registers. Long runs of random writes, mode flips and enable drops add more unplanned collisions of this kind. Illegal periods of 0 and 1 are mixed into those runs.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY_A = 2'd1,
    SEL_DUTY_B = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
  import pwm_pkg::*;
#(
  parameter int W     = 16,
  parameter int NPAIR = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_addr,
  input  logic [W-1:0]               wr_data,
  output logic [W-1:0]               stg_period,
  output logic [NPAIR-1:0][W-1:0]    stg_duty
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_period <= '0;
      stg_duty   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_PERIOD: stg_period  <= wr_data;
        SEL_DUTY_A: stg_duty[0] <= wr_data;
        SEL_DUTY_B: stg_duty[1] <= wr_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W     = 16,
  parameter int NPAIR = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    center_mode,
  input  logic [W-1:0]            stg_period,
  input  logic [NPAIR-1:0][W-1:0] stg_duty,
  output logic                    running,
  output logic [W-1:0]            cnt,
  output logic                    down,
  output logic                    act_center,
  output logic [W-1:0]            act_period,
  output logic [NPAIR-1:0][W-1:0] act_duty,
  output logic                    sync
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] MIN_PERIOD = W'(2);

  logic last_tick;
  logic start_ev;

  function automatic logic period_done(input logic ctr, input logic dn,
                                       input logic [W-1:0] c, input logic [W-1:0] p);
    if (ctr) return dn && (c == ONE);
    return c == (p - ONE);
  endfunction

  assign last_tick = running && period_done(act_center, down, cnt, act_period);
  assign start_ev  = en && (!running || last_tick);
  assign sync      = running && (cnt == '0) && !down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      cnt        <= '0;
      down       <= 1'b0;
      act_center <= 1'b0;
      act_period <= '0;
      act_duty   <= '0;
    end else if (!en) begin
      running <= 1'b0;
      cnt     <= '0;
      down    <= 1'b0;
    end else if (start_ev) begin
      act_period <= stg_period;
      act_duty   <= stg_duty;
      act_center <= center_mode;
      running    <= (stg_period >= MIN_PERIOD);
      cnt        <= '0;
      down       <= 1'b0;
    end else if (act_center && down) begin
      cnt <= cnt - ONE;
    end else begin
      if (act_center && (cnt == act_period - ONE)) down <= 1'b1;
      cnt <= cnt + ONE;
    end
  end

  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running && !act_center |-> cnt < act_period && !down); // R1
  AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running && act_center |-> cnt <= act_period); // R2
  AST_SYNC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync); // R1
  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    en && !start_ev |=> $stable(act_period) && $stable(act_duty) && $stable(act_center)); // R8
  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev && (stg_period < MIN_PERIOD) |=> !running && !sync); // R7
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running && cnt == '0); // R9
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         running,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  output logic         hi,
  output logic         lo
);
  logic [W-1:0] duty_c;
  logic         on_now;

  function automatic logic [W-1:0] clamp_duty(input logic [W-1:0] d, input logic [W-1:0] p);
    if (d[W-1]) return '0;
    if (d >= p) return p;
    return d;
  endfunction

  function automatic logic in_window(input logic [W-1:0] c, input logic dn, input logic [W-1:0] d);
    if (dn) return c <= d;
    return c < d;
  endfunction

  assign duty_c = clamp_duty(duty, period);
  assign on_now = in_window(cnt, down, duty_c);
  assign hi     = running && on_now;
  assign lo     = running && !on_now;

  AST_NEG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    duty[W-1] |-> !hi); // R6
  AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    running && !duty[W-1] && duty >= period |-> hi); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !hi && !lo); // R5
endmodule

// File: rtl/pwm_dual_pair.sv
module pwm_dual_pair #(
  parameter int W     = 16,
  parameter int NPAIR = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         center_mode,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         a_hi,
  output logic         a_lo,
  output logic         b_hi,
  output logic         b_lo,
  output logic         sync
);
  logic [W-1:0]            stg_period;
  logic [NPAIR-1:0][W-1:0] stg_duty;
  logic                    running;
  logic [W-1:0]            cnt;
  logic                    down;
  logic                    act_center;
  logic [W-1:0]            act_period;
  logic [NPAIR-1:0][W-1:0] act_duty;
  logic [NPAIR-1:0]        hi_v;
  logic [NPAIR-1:0]        lo_v;

  pwm_stage_regs #(.W(W), .NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stg_period(stg_period), .stg_duty(stg_duty)
  );

  pwm_timebase #(.W(W), .NPAIR(NPAIR)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .center_mode(center_mode),
    .stg_period(stg_period), .stg_duty(stg_duty), .running(running),
    .cnt(cnt), .down(down), .act_center(act_center),
    .act_period(act_period), .act_duty(act_duty), .sync(sync)
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    pwm_pair_out #(.W(W)) u_pair (
      .clk(clk), .rst_n(rst_n), .running(running), .cnt(cnt), .down(down),
      .period(act_period), .duty(act_duty[g]), .hi(hi_v[g]), .lo(lo_v[g])
    );
  end

  assign a_hi = hi_v[0];
  assign a_lo = lo_v[0];
  assign b_hi = hi_v[1];
  assign b_lo = lo_v[1];

  AST_PAIR_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (a_lo == !a_hi) && (b_lo == !b_hi)); // R5
  AST_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    en && !running && (stg_period >= W'(2)) |=> sync); // R9
endmodule

// File: tb/test_pwm_dual_pair.sv
module test_pwm_dual_pair;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        center_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        a_hi, a_lo, b_hi, b_lo, sync;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R5";

  // behavioural reference state
  int    m_per = 0, m_pos = 0, st_per = 0;
  int    m_da = 0, m_db = 0, st_da = 0, st_db = 0;
  bit    m_run = 0, m_ctr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_pair i_pwm_dual_pair (
    .clk(clk), .rst_n(rst_n), .en(en), .center_mode(center_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .sync(sync)
  );

  function automatic int span();
    return m_ctr ? 2 * m_per : m_per;
  endfunction

  function automatic bit lit(input int d);
    int dc;
    dc = (d < 0) ? 0 : ((d >= m_per) ? m_per : d);
    if (m_pos < dc) return 1'b1;
    return m_ctr && (m_pos >= 2 * m_per - dc);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_per = 0; m_da = 0; m_db = 0; m_ctr = 0;
      st_per = 0; st_da = 0; st_db = 0;
    end else begin
      if (!en) begin
        m_run = 0; m_pos = 0;
      end else if (!m_run || m_pos == span() - 1) begin
        m_per = st_per; m_da = st_da; m_db = st_db; m_ctr = center_mode;
        m_run = (st_per >= 2); m_pos = 0;
      end else begin
        m_pos++;
      end
      if (wr_en) begin
        if (wr_addr == 2'd0) st_per = int'(wr_data);
        else if (wr_addr == 2'd1) st_da = int'($signed(wr_data));
        else if (wr_addr == 2'd2) st_db = int'($signed(wr_data));
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s t=%0t got %0b exp %0b", cur_req, what, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      chk(a_hi, m_run && lit(m_da), "a_hi");
      chk(a_lo, m_run && !lit(m_da), "a_lo");
      chk(b_hi, m_run && lit(m_db), "b_hi");
      chk(b_lo, m_run && !lit(m_db), "b_lo");
      chk(sync, m_run && m_pos == 0, "sync");
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_on_boundary(input logic [1:0] a, input logic [15:0] d);
    int guard = 0;
    while (!(m_run && m_pos == span() - 1) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    wr(a, d);
  endtask

  initial begin
    tick(3);
    cur_req = "R5"; // reset state: all outputs low
    chk(a_hi, 1'b0, "reset a_hi"); chk(a_lo, 1'b0, "reset a_lo");
    chk(b_lo, 1'b0, "reset b_lo"); chk(sync, 1'b0, "reset sync");
    rst_n = 1'b1;
    tick(2);

    cur_req = "R7"; // en high with period 0 staged: stays idle
    en = 1'b1; tick(8);

    cur_req = "R10"; // address map, edge mode
    wr(2'd0, 16'd10); wr(2'd1, 16'd3); wr(2'd2, 16'd7);
    cur_req = "R1"; tick(35);
    cur_req = "R3"; wr(2'd1, 16'd5); tick(25);
    cur_req = "R8"; wr(2'd2, 16'd1); tick(4); wr(2'd0, 16'd6); tick(25);

    cur_req = "R2"; center_mode = 1'b1; wr(2'd0, 16'd8); tick(40);
    cur_req = "R4"; wr(2'd1, 16'd3); wr(2'd2, 16'd8); tick(40);
    cur_req = "R6"; wr(2'd1, 16'hFFFB); wr(2'd2, 16'd300); tick(40);
    center_mode = 1'b0; wr(2'd1, 16'h8000); wr(2'd2, 16'd8); tick(30);

    cur_req = "R10"; wr(2'd3, 16'd1); wr(2'd3, 16'd50); tick(30);

    cur_req = "R7"; wr(2'd0, 16'd1); tick(20); wr(2'd0, 16'd0); tick(15);
    wr(2'd0, 16'd2); wr(2'd1, 16'd1); tick(12);
    center_mode = 1'b1; tick(12);

    cur_req = "R9"; wr(2'd0, 16'd9); tick(7); en = 1'b0; tick(5);
    en = 1'b1; tick(30); en = 1'b0; tick(1); en = 1'b1; tick(20);

    cur_req = "R8"; // writes on the final tick of a period
    for (int k = 0; k < 4; k++) begin
      center_mode = k[0];
      wr_on_boundary(2'd0, 16'(5 + k));
      wr_on_boundary(2'd1, 16'(2 + k));
      wr_on_boundary(2'd2, 16'(k));
      tick(20);
    end

    cur_req = "R1"; center_mode = 1'b0; wr(2'd0, 16'h1000); wr(2'd1, 16'h0800);
    wr(2'd2, 16'h7FFF); tick(4200);

    cur_req = "R8"; // random mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) wr(2'(r % 4), 16'($urandom_range(0, 40)));
      else if (r < 12) wr(2'd1 + 2'(r % 2), 16'($signed(-($urandom_range(0, 4)))));
      else if (r < 14) center_mode = ~center_mode;
      else if (r < 15) en = 1'b0;
      else if (r < 20) en = 1'b1;
      else tick(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    n_bad++;
    $display("FAIL %s watchdog got %0d exp %0d", cur_req, cycles, WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule